// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar and raises an alarm when a chosen subset of its fields reaches programmed values. Six alarm bytes hold targets for seconds, minutes, hours, weekday, day of month and month. In each byte the top bit arms the compare for that field and the lower seven bits hold the target in BCD, so software can build anything from a once-a-minute match to a single yearly date. The year takes no part in the compare.

The calendar counters live outside the block. They arrive as BCD bytes on a flat input together with a one-cycle pulse that marks each seconds update. The compare is evaluated only on that pulse, so a matching second sets the alarm flag once. The flag stays set until software clears it, and it drives a level interrupt while the interrupt enable is set. All alarm bytes and the control byte are reached through a simple byte-wide register port.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset every alarm byte reads 0x00, the control byte reads 0x00, and both alarm_flag_o and alarm_irq_o are low.
- R2: Addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, weekday, day of month and month. A write stores the full byte, and a read at that address returns it. Bit 7 is the field's compare enable and bits 6:0 are the BCD target.
- R3: Address 6 is the control byte. Bit 0 reads back the alarm flag, bit 3 is the interrupt enable and is written directly, and all other bits read 0.
- R4: When sec_tick_i is high, at least one alarm byte has bit 7 set, and every armed field equals its time byte (time byte == {1'b0, target}), the flag is set at the next clock edge. Field i of time_bcd_i is bits 8*i+7:8*i, in the same order as the addresses.
- R5: A field whose alarm byte has bit 7 clear is a don't-care. When all six bytes are disarmed (for example all written 0x00), the flag never sets, whatever the time.
- R6: The flag does not set in a cycle where sec_tick_i is low, even if every armed field matches.
- R7: A control write with bit 0 at 0 clears the flag at the next edge. A control write with bit 0 at 1 leaves the flag unchanged and never sets it.
- R8: If a set event and a clearing control write happen in the same cycle, the flag ends up set.
- R9: alarm_irq_o is high exactly while the flag and the interrupt enable are both set. It is a level signal and stays high across later non-matching ticks until the flag is cleared.
- R10: A mismatch in any single armed field, including the month (numbered 1 to 12, the same as the counter), prevents the flag from setting.
- R11: Address 7 reads 0x00, and writes to it change no alarm byte and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse, high when the seconds counter updates |
| time_bcd_i | input | 48 | Current BCD time; byte i is field i (sec, min, hour, weekday, day, month) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| alarm_flag_o | output | 1 | Alarm flag |
| alarm_irq_o | output | 1 | Level alarm interrupt |

## Verification
On every cycle, the assertions check that register writes land in the addressed alarm byte and that the flag follows its set and clear rules: a set event always takes effect, a clear without a set always takes effect, a collision always resolves to set, and the flag never rises without a set event. They also check that the interrupt is never high while the flag is low. Whether the comparator produces the set event under the right conditions can only be shown by the bench scenarios. That covers don't-care fields, the all-disarmed case with an all-zero time, single-field mismatches, month matching, and matches that arrive without a tick. The bench runs these against its own model of the register file and flag.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int TIME_W     = NUM_FIELDS * BYTE_W;
  localparam int CTRL_ADDR  = NUM_FIELDS;
  localparam int ARM_BIT    = BYTE_W - 1;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  byte_t                           wdata_i,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_o
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   alm_q[i] <= '0;
      else if (wr_en_i && (int'(addr_i) == i))       alm_q[i] <= wdata_i;
    end
  end

  assign alm_o = alm_q;

  // R2
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(addr_i) < NUM_FIELDS)) |=> (alm_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic                              tick_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_i,
  input  logic [TIME_W-1:0]                 time_i,
  output logic                              set_o
);
  logic [NUM_FIELDS-1:0] armed;
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    assign armed[i]  = alm_i[i][ARM_BIT];
    // disarmed fields pass; armed need bit7 of time clear and low bits equal
    assign fld_ok[i] = !armed[i] ||
                       (time_i[i*BYTE_W +: BYTE_W] == {1'b0, alm_i[i][ARM_BIT-1:0]});
  end

  assign set_o = tick_i && (|armed) && (&fld_ok);
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ctrl_wr_i,
  input  logic wr_flag_i,
  input  logic wr_ie_i,
  output logic flag_o,
  output logic ie_o
);
  logic flag_q, ie_q, clr;

  assign clr = ctrl_wr_i && !wr_flag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= set_i || (flag_q && !clr);  // set has priority over clear
      if (ctrl_wr_i) ie_q <= wr_ie_i;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;

  // R4
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R7
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> !flag_q);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && set_i) |=> flag_q);
  // R6
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic [TIME_W-1:0] time_bcd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              alarm_flag_o,
  output logic              alarm_irq_o
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm;
  logic  set_ev, flag, ie, ctrl_wr;
  byte_t ctrl_byte;

  assign ctrl_wr = wr_en_i && (int'(addr_i) == CTRL_ADDR);

  rtc_alarm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .alm_o   (alm)
  );

  rtc_alarm_match u_match (
    .tick_i (sec_tick_i),
    .alm_i  (alm),
    .time_i (time_bcd_i),
    .set_o  (set_ev)
  );

  rtc_alarm_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_ev),
    .ctrl_wr_i (ctrl_wr),
    .wr_flag_i (wdata_i[FLAG_BIT]),
    .wr_ie_i   (wdata_i[IE_BIT]),
    .flag_o    (flag),
    .ie_o      (ie)
  );

  always_comb begin
    ctrl_byte           = '0;
    ctrl_byte[FLAG_BIT] = flag;
    ctrl_byte[IE_BIT]   = ie;
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < NUM_FIELDS)        rdata_o = alm[addr_i];
    else if (int'(addr_i) == CTRL_ADDR)   rdata_o = ctrl_byte;
  end

  assign alarm_flag_o = flag;
  assign alarm_irq_o  = flag && ie;

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> alarm_flag_o);
endmodule

// File: tb/rtc_alarm_cmp_tb.sv
module rtc_alarm_cmp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_tick_i = 1'b0;
  logic [47:0] time_bcd_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        alarm_flag_o, alarm_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_alm [6];
  bit m_flag, m_ie;

  always #2 clk_i = ~clk_i;

  rtc_alarm_cmp u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [47:0] t);
    bit any = 1'b0;
    bit ok  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (m_alm[i][7]) begin
        any = 1'b1;
        if (t[i*8 +: 8] != {1'b0, m_alm[i][6:0]}) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  // one clock cycle: drive at negedge, model update, compare at next negedge
  task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d,
                      input bit tk, input logic [47:0] t, input string req);
    bit set_e, clr_e;
    wr_en_i = we; addr_i = a; wdata_i = d; sec_tick_i = tk; time_bcd_i = t;
    set_e = tk && exp_hit(t);
    clr_e = we && (a == 3'd6) && !d[0];
    @(negedge clk_i);
    if (we && a < 3'd6) m_alm[a] = d;
    if (we && a == 3'd6) m_ie = d[3];
    m_flag = set_e || (m_flag && !clr_e);
    wr_en_i = 1'b0; sec_tick_i = 1'b0;
    chk(req, alarm_flag_o, m_flag);
    chk({req, "/R9"}, alarm_irq_o, m_flag && m_ie);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    logic [7:0] e;
    wr_en_i = 1'b0; sec_tick_i = 1'b0; addr_i = a;
    #1;
    if (a < 3'd6)       e = m_alm[a];
    else if (a == 3'd6) e = {4'b0, m_ie, 2'b0, m_flag};
    else                e = 8'h00;
    chk(req, rdata_o, e);
  endtask

  function automatic logic [47:0] tm(input logic [7:0] s, mi, h, w, dd, mo);
    return {mo, dd, w, h, mi, s};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
    m_flag = 1'b0; m_ie = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a[2:0], "R1 reset read");
    chk("R1 flag", alarm_flag_o, 1'b0);
    chk("R1 irq", alarm_irq_o, 1'b0);

    // R2 write / read-back
    for (int a = 0; a < 6; a++) step(1'b1, a[2:0], 8'h11 + 8'(a), 1'b0, '0, "R2 write");
    for (int a = 0; a < 6; a++) rd(a[2:0], "R2 readback");
    // R11 address 7
    step(1'b1, 3'd7, 8'hFF, 1'b0, '0, "R11 write");
    for (int a = 0; a < 8; a++) rd(a[2:0], "R11 no effect");

    // R3 / R7: writing bit0=1 does not set flag
    step(1'b1, 3'd6, 8'hFF, 1'b0, '0, "R7 write one");
    rd(3'd6, "R3 ctrl readback");

    // R4 seconds+minutes armed, rest disarmed
    for (int a = 0; a < 6; a++) step(1'b1, a[2:0], 8'h00, 1'b0, '0, "R5 clear");
    step(1'b1, 3'd0, 8'hB0, 1'b0, '0, "R2 sec");
    step(1'b1, 3'd1, 8'h95, 1'b0, '0, "R2 min");
    // R6 match without tick
    step(1'b0, 3'd0, 8'h00, 1'b0, tm(8'h30, 8'h15, 8'h07, 8'h02, 8'h21, 8'h04), "R6 no tick");
    // R10 minute mismatch
    step(1'b0, 3'd0, 8'h00, 1'b1, tm(8'h30, 8'h16, 8'h07, 8'h02, 8'h21, 8'h04), "R10 min mismatch");
    // R4 match, don't-care hours etc.
    step(1'b0, 3'd0, 8'h00, 1'b1, tm(8'h30, 8'h15, 8'h23, 8'h06, 8'h31, 8'h12), "R4 match");
    chk("R4 flag up", alarm_flag_o, 1'b1);
    chk("R9 irq up", alarm_irq_o, 1'b1);
    // R9 stays across non-matching ticks
    step(1'b0, 3'd0, 8'h00, 1'b1, tm(8'h31, 8'h15, 8'h00, 8'h00, 8'h01, 8'h01), "R9 level");
    rd(3'd6, "R3 ctrl flag");
    // R7 clear
    step(1'b1, 3'd6, 8'h08, 1'b0, '0, "R7 clear");
    chk("R7 flag low", alarm_flag_o, 1'b0);
    // R8 set and clear together
    step(1'b1, 3'd6, 8'h08, 1'b1, tm(8'h30, 8'h15, 8'h00, 8'h00, 8'h01, 8'h01), "R8 set wins");
    chk("R8 flag", alarm_flag_o, 1'b1);
    // R9 ie off
    step(1'b1, 3'd6, 8'h01, 1'b0, '0, "R9 ie off");
    chk("R9 irq off", alarm_irq_o, 1'b0);
    step(1'b1, 3'd6, 8'h00, 1'b0, '0, "R7 clear2");

    // R5 all disarmed, all-zero time
    step(1'b1, 3'd0, 8'h00, 1'b0, '0, "R5 disarm");
    step(1'b1, 3'd1, 8'h00, 1'b0, '0, "R5 disarm");
    step(1'b0, 3'd0, 8'h00, 1'b1, '0, "R5 zero time");
    chk("R5 no flag", alarm_flag_o, 1'b0);

    // R10 month only: 1..12
    step(1'b1, 3'd5, 8'h92, 1'b0, '0, "R10 mon arm");
    step(1'b0, 3'd0, 8'h00, 1'b1, tm(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h11), "R10 mon mismatch");
    step(1'b0, 3'd0, 8'h00, 1'b1, tm(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h12), "R4 mon match");
    chk("R4 mon flag", alarm_flag_o, 1'b1);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom % 4;
      if (op == 0) begin
        logic [2:0] a = 3'($urandom % 6);
        logic [7:0] v = {1'($urandom % 3 == 0), 3'($urandom % 3), 4'($urandom % 10)};
        step(1'b1, a, v, 1'($urandom % 2), {$urandom, $urandom} , "R2/R4 rnd write");
      end else if (op == 1) begin
        step(1'b1, ($urandom % 8 == 0) ? 3'd7 : 3'd6, 8'($urandom), 1'($urandom % 2),
             '0, "R7/R8 rnd ctrl");
      end else if (op == 2) begin
        logic [47:0] t;
        for (int i = 0; i < 6; i++)
          t[i*8 +: 8] = ($urandom % 8 == 0) ? 8'($urandom % 64) : {1'b0, m_alm[i][6:0]};
        step(1'b0, 3'd0, 8'h00, 1'($urandom % 4 != 0), t, "R4/R5/R10 rnd tick");
      end else begin
        rd(3'($urandom % 8), "R2/R3/R11 rnd read");
        @(negedge clk_i);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule